// File: doc/BRIEF.md
# SPI Master Controller

This block is a register-programmed SPI master. Software sets a mode word that picks the clock phase and idle level, the bit order, an internal loopback path, the character length and a two-stage clock prescaler. Writing the data register starts one full-duplex character. The block drives the serial clock and the outgoing data line and samples the incoming line. When the character completes, the received bits appear in the data register and a sticky event flag is raised. A per-flag mask turns event flags into a level interrupt.

The register port is a plain single-cycle bus. A write takes effect on the clock edge at which `bus_wr` is high. Reads are combinational from `bus_addr` and have no side effects, so this port has neither back-pressure nor a ready signal. Software holds off overlapping characters by waiting for the transmit-free flag. A write that arrives while a character is still pending is dropped and recorded. Chip selects are driven outside the block.

Register addresses: 0 = mode, 1 = event, 2 = mask, 3 = data.
Event and mask bit positions: bit 0 = receive ready, bit 1 = transmit free, bit 2 = overrun.

Top module: `spi_master_ctl`

## Requirements
- R1: The character length field is mode[13:10]. A value of 0 selects 32 bits and any other value L selects L+1 bits. The received character appears right-aligned in the data register, with every bit above the length cleared.
- R2: With mode[5] clear, one serial clock period lasts 4×(P+1) system clocks, where P is the prescale field mode[9:6]. With mode[5] set, the period lasts 64×(P+1) system clocks.
- R3: mode[2] sets the idle level of the serial clock. mode[1] = 0 samples on the leading edge and mode[1] = 1 samples on the trailing edge. A character exchanged in loopback is returned intact in both phases.
- R4: When mode[3] = 1 the most significant bit of the character is sent first. When mode[3] = 0 the least significant bit is sent first.
- R5: When mode[4] = 1 the receiver takes the outgoing data line and ignores `spi_miso`. When mode[4] = 0 the receiver samples `spi_miso`.
- R6: While mode[0] (enable) is clear the shifter is held idle. The serial clock stays at its idle level, and a data write neither starts a character nor sets any flag.
- R7: Event bit 0 sets when a character completes. It stays set through reads of the data register, and only a write of 1 to event bit 0 clears it.
- R8: `irq` is high exactly when some event bit and its mask bit are both set. With the mask at zero, `irq` stays low.
- R9: Event bit 1 reads 1 whenever the transmit holding stage is empty. After a data write it reads 0 for one cycle, until the character moves into the shifter. After reset the event register reads 0x2.
- R10: A data write while enabled and while a character is pending or shifting is dropped and sets event bit 2. The character in progress completes unchanged. Writing 1 to event bit 2 clears it.
- R11: With mode[14] set, the transmit and receive positions inside the 32-bit data word depend on length and order:
  - MSB-first, up to 8 bits: transmit from bit 24, receive to bit 16.
  - MSB-first, 9 to 16 bits: both at bit 16.
  - LSB-first, up to 8 bits: receive to bit 8.
  - Every other combination uses bit 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, also the baud source |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_wr | input | 1 | Register write strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for bus_addr |
| spi_sck | output | 1 | Serial clock |
| spi_mosi | output | 1 | Serial data out |
| spi_miso | input | 1 | Serial data in |
| irq | output | 1 | Masked event interrupt |

## Verification
The assertions rely on the following input behaviour:
- Software clears enable before it changes phase, polarity, length or prescale, and only then sets enable again. Under that rule, an idle shifter always shows the programmed clock level.
- `bus_addr` and `bus_wr` are stable around each rising edge.

The bench keeps within these limits in three ways:
- Every mode change goes through a disable-then-enable write pair.
- Inputs are driven only on falling edges.
- A new character is sent only after the previous one has been collected, except in the one test that deliberately provokes an overrun.

// File: rtl/spi_mc_pkg.sv
package spi_mc_pkg;
  typedef enum logic [1:0] {
    A_MODE  = 2'd0,
    A_EVENT = 2'd1,
    A_MASK  = 2'd2,
    A_DATA  = 2'd3
  } reg_addr_e;

  localparam int EV_NE  = 0;
  localparam int EV_NF  = 1;
  localparam int EV_OVR = 2;
  localparam int EV_W   = 3;
  localparam int MODE_W = 15;

  typedef struct packed {
    logic       alt;
    logic [3:0] len;
    logic [3:0] pm;
    logic       div16;
    logic       loopb;
    logic       msb;
    logic       cpol;
    logic       cpha;
    logic       en;
  } mode_t;
endpackage

// File: rtl/spi_mc_baud.sv
module spi_mc_baud #(
  parameter int PM_W     = 4,
  parameter int FAST_MUL = 2,
  parameter int SLOW_MUL = 32
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            run,
  input  logic            div16,
  input  logic [PM_W-1:0] pm,
  output logic            tick
);
  localparam int CNT_W = $clog2(SLOW_MUL * (2 ** PM_W)) + 1;

  logic [CNT_W-1:0] cnt_q;
  logic [CNT_W-1:0] pm_ext;
  logic [CNT_W-1:0] half;
  logic [CNT_W-1:0] half_m1;

  assign pm_ext  = CNT_W'(pm) + CNT_W'(1);
  assign half    = div16 ? pm_ext * CNT_W'(SLOW_MUL) : pm_ext * CNT_W'(FAST_MUL);
  assign half_m1 = half - CNT_W'(1);
  assign tick    = run && (cnt_q == half_m1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)             cnt_q <= '0;
    else if (!run || tick)  cnt_q <= '0;
    else                    cnt_q <= cnt_q + CNT_W'(1);
  end
endmodule

// File: rtl/spi_mc_shift.sv
module spi_mc_shift #(
  parameter int DATA_W = 32,
  parameter int NB_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              enable,
  input  logic              cpha,
  input  logic              cpol,
  input  logic              msb_first,
  input  logic              loopb,
  input  logic [NB_W-1:0]   nbits,
  input  logic              load,
  input  logic [DATA_W-1:0] load_char,
  input  logic              miso,
  input  logic              tick,
  output logic              sck,
  output logic              mosi,
  output logic              busy,
  output logic              done,
  output logic [DATA_W-1:0] rx_char
);
  localparam int IDX_W = $clog2(DATA_W);
  localparam logic [NB_W:0] ONE_E = (NB_W+1)'(1);

  logic [DATA_W-1:0] tx_q, rx_q;
  logic [NB_W:0]     edge_q;
  logic [NB_W-1:0]   tx_i, rx_i;
  logic [NB_W:0]     last_edge;
  logic [IDX_W-1:0]  rx_k;
  logic              lead, din, sample_now, drive_now;

  function automatic logic pick_bit(input logic [DATA_W-1:0] w, input logic [NB_W-1:0] i,
                                    input logic [NB_W-1:0] n, input logic msb);
    logic [IDX_W-1:0] k;
    k = IDX_W'(msb ? (n - NB_W'(1) - i) : i);
    return w[k];
  endfunction

  assign last_edge  = {nbits, 1'b0} - ONE_E;
  assign lead       = ~edge_q[0];
  assign din        = loopb ? mosi : miso;
  assign sample_now = cpha ? !lead : lead;
  assign drive_now  = cpha ? (lead && edge_q != '0) : (!lead && edge_q != last_edge);
  assign rx_k       = IDX_W'(msb_first ? (nbits - NB_W'(1) - rx_i) : rx_i);
  assign rx_char    = rx_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0; done <= 1'b0; sck <= 1'b0; mosi <= 1'b0;
      tx_q <= '0; rx_q <= '0; edge_q <= '0; tx_i <= '0; rx_i <= '0;
    end else begin
      done <= 1'b0;
      if (!enable) begin
        busy <= 1'b0;
        sck  <= cpol;
      end else if (!busy) begin
        sck <= cpol;
        if (load) begin
          busy   <= 1'b1;
          tx_q   <= load_char;
          rx_q   <= '0;
          edge_q <= '0;
          tx_i   <= '0;
          rx_i   <= '0;
          mosi   <= pick_bit(load_char, '0, nbits, msb_first);
        end
      end else if (tick) begin
        sck <= ~sck;
        if (sample_now) begin
          rx_q[rx_k] <= din;
          rx_i       <= rx_i + NB_W'(1);
        end
        if (drive_now) begin
          tx_i <= tx_i + NB_W'(1);
          mosi <= pick_bit(tx_q, tx_i + NB_W'(1), nbits, msb_first);
        end
        if (edge_q == last_edge) begin
          busy <= 1'b0;
          done <= 1'b1;
        end else begin
          edge_q <= edge_q + ONE_E;
        end
      end
    end
  end
endmodule

// File: rtl/spi_mc_regs.sv
module spi_mc_regs
  import spi_mc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int NB_W   = $clog2(DATA_W) + 1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  input  logic              busy,
  input  logic              done,
  input  logic [DATA_W-1:0] rx_char,
  output mode_t             mode_o,
  output logic [NB_W-1:0]   nbits,
  output logic              load,
  output logic [DATA_W-1:0] load_char,
  output logic [EV_W-1:0]   mask_o,
  output logic              ne_o,
  output logic              ovr_o,
  output logic              irq
);
  localparam int IDX_W = $clog2(DATA_W);

  mode_t             mode_q;
  logic [EV_W-1:0]   mask_q, ev_vec;
  logic              hold_v, ne_q, ovr_q;
  logic [DATA_W-1:0] hold_q, rxd_q;
  logic              wr_mode, wr_event, wr_mask, wr_data, accept;
  logic [IDX_W-1:0]  tx_off, rx_off;

  assign wr_mode  = bus_wr && (bus_addr == A_MODE);
  assign wr_event = bus_wr && (bus_addr == A_EVENT);
  assign wr_mask  = bus_wr && (bus_addr == A_MASK);
  assign wr_data  = bus_wr && (bus_addr == A_DATA);
  assign accept   = wr_data && mode_q.en && !hold_v && !busy;
  assign load     = hold_v && !busy && mode_q.en;

  assign nbits = (mode_q.len == '0) ? NB_W'(DATA_W) : NB_W'(mode_q.len) + NB_W'(1);

  always_comb begin
    tx_off = '0;
    rx_off = '0;
    if (mode_q.alt) begin
      if (mode_q.msb && nbits <= NB_W'(8)) begin
        tx_off = IDX_W'(24);
        rx_off = IDX_W'(16);
      end else if (mode_q.msb && nbits <= NB_W'(16)) begin
        tx_off = IDX_W'(16);
        rx_off = IDX_W'(16);
      end else if (!mode_q.msb && nbits <= NB_W'(8)) begin
        rx_off = IDX_W'(8);
      end
    end
  end

  assign load_char = hold_q >> tx_off;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q <= '0; mask_q <= '0; hold_v <= 1'b0; hold_q <= '0;
      ne_q <= 1'b0; ovr_q <= 1'b0; rxd_q <= '0;
    end else begin
      if (wr_mode) mode_q <= mode_t'(bus_wdata[MODE_W-1:0]);
      if (wr_mask) mask_q <= bus_wdata[EV_W-1:0];
      if (!mode_q.en)  hold_v <= 1'b0;
      else if (accept) begin
        hold_v <= 1'b1;
        hold_q <= bus_wdata;
      end else if (load) hold_v <= 1'b0;
      if (wr_data && mode_q.en && !accept)      ovr_q <= 1'b1;
      else if (wr_event && bus_wdata[EV_OVR])   ovr_q <= 1'b0;
      if (done) begin
        ne_q  <= 1'b1;
        rxd_q <= rx_char << rx_off;
      end else if (wr_event && bus_wdata[EV_NE]) ne_q <= 1'b0;
    end
  end

  always_comb begin
    ev_vec = '0;
    ev_vec[EV_NE]  = ne_q;
    ev_vec[EV_NF]  = !hold_v;
    ev_vec[EV_OVR] = ovr_q;
  end

  always_comb begin
    unique case (bus_addr)
      A_MODE:  bus_rdata = DATA_W'(mode_q);
      A_EVENT: bus_rdata = DATA_W'(ev_vec);
      A_MASK:  bus_rdata = DATA_W'(mask_q);
      default: bus_rdata = rxd_q;
    endcase
  end

  assign irq    = |(ev_vec & mask_q);
  assign mode_o = mode_q;
  assign mask_o = mask_q;
  assign ne_o   = ne_q;
  assign ovr_o  = ovr_q;
endmodule

// File: rtl/spi_master_ctl.sv
module spi_master_ctl
  import spi_mc_pkg::*;
#(
  parameter int DATA_W = 32,
  parameter int PM_W   = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              spi_sck,
  output logic              spi_mosi,
  input  logic              spi_miso,
  output logic              irq
);
  localparam int NB_W = $clog2(DATA_W) + 1;

  mode_t             mode_w;
  logic [NB_W-1:0]   nbits_w;
  logic              load_w, busy_w, done_w, tick_w, ne_w, ovr_w;
  logic [DATA_W-1:0] load_char_w, rx_char_w;
  logic [EV_W-1:0]   mask_w;

  spi_mc_regs #(.DATA_W(DATA_W), .NB_W(NB_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .busy(busy_w), .done(done_w),
    .rx_char(rx_char_w), .mode_o(mode_w), .nbits(nbits_w), .load(load_w),
    .load_char(load_char_w), .mask_o(mask_w), .ne_o(ne_w), .ovr_o(ovr_w), .irq(irq)
  );

  spi_mc_baud #(.PM_W(PM_W)) u_baud (
    .clk(clk), .rst_n(rst_n), .run(busy_w), .div16(mode_w.div16),
    .pm(PM_W'(mode_w.pm)), .tick(tick_w)
  );

  spi_mc_shift #(.DATA_W(DATA_W), .NB_W(NB_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .enable(mode_w.en), .cpha(mode_w.cpha),
    .cpol(mode_w.cpol), .msb_first(mode_w.msb), .loopb(mode_w.loopb),
    .nbits(nbits_w), .load(load_w), .load_char(load_char_w), .miso(spi_miso),
    .tick(tick_w), .sck(spi_sck), .mosi(spi_mosi), .busy(busy_w), .done(done_w),
    .rx_char(rx_char_w)
  );
endmodule

// File: rtl/spi_mc_chk.sv
module spi_mc_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       bus_wr,
  input logic [1:0] bus_addr,
  input logic       en,
  input logic       cpol,
  input logic       busy,
  input logic       tick,
  input logic       done,
  input logic       sck,
  input logic       ne,
  input logic       ovr,
  input logic [2:0] mask,
  input logic       irq
);
  // R3: an idle shifter shows the programmed idle level
  p_sck_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!busy && !$past(busy) && cpol == $past(cpol)) |-> sck == cpol);

  // R2: during a character the clock only moves after a prescaler tick
  p_sck_tick_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (busy && $past(busy) && sck != $past(sck)) |-> $past(tick));

  // R6: clearing enable leaves the shifter idle
  p_disabled_idle_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !en |=> !busy);

  // R7: receive-ready rises only after a completed character
  p_ne_after_shift_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ne) |-> $past(done));

  // R8: no interrupt with an empty mask
  p_irq_mask_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mask == 3'b000) |-> !irq);

  // R10: a data write during a character flags overrun
  p_ovr_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_wr && bus_addr == 2'd3 && en && busy) |=> ovr);
endmodule

bind spi_master_ctl spi_mc_chk u_chk (
  .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
  .en(mode_w.en), .cpol(mode_w.cpol), .busy(busy_w), .tick(tick_w),
  .done(done_w), .sck(spi_sck), .ne(ne_w), .ovr(ovr_w), .mask(mask_w), .irq(irq)
);

// File: tb/tb_spi_master_ctl.sv
`timescale 1ns/1ps
module tb_spi_master_ctl;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0;
  logic [1:0]  bus_addr = 2'd0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        spi_sck, spi_mosi, irq;
  logic        miso_drv = 1'b0;

  int n_checks = 0;
  int n_fail = 0;
  int sb_done = 0;
  logic [31:0] exp_q[$];

  always #10 clk = ~clk;

  spi_master_ctl dut (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .spi_sck(spi_sck),
    .spi_mosi(spi_mosi), .spi_miso(miso_drv), .irq(irq)
  );

  task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: got %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(posedge clk);
    #1 bus_wr = 1'b0;
  endtask

  task automatic bus_read(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  function automatic logic [31:0] mk(input bit en, cpha, cpol, msb, lp, d16,
                                     input int pm, input int len, input bit alt);
    return {17'd0, alt, 4'(len), 4'(pm), d16, lp, msb, cpol, cpha, en};
  endfunction

  task automatic set_mode(input logic [31:0] m);
    bus_write(2'd0, m & ~32'd1);
    bus_write(2'd0, m);
  endtask

  task automatic send(input logic [31:0] tx, input logic [31:0] expv);
    int target;
    target = sb_done + 1;
    exp_q.push_back(expv);
    bus_write(2'd3, tx);
    wait (sb_done == target);
  endtask

  task automatic wait_ne();
    logic [31:0] d;
    d = '0;
    while (d[0] !== 1'b1) bus_read(2'd1, d);
  endtask

  // monitor: collects each finished character and compares against the queue
  initial begin
    logic [31:0] d, e;
    forever begin
      @(negedge clk);
      if (irq && exp_q.size() > 0) begin
        bus_read(2'd3, d);
        e = exp_q.pop_front();
        check("R1 scoreboard", d, e);
        bus_write(2'd1, 32'd1);
        sb_done++;
      end
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    logic [31:0] d, prev;
    int cnt, bad;
    repeat (3) @(posedge clk);
    #1 rst_n = 1'b1;

    // R9 reset state
    bus_read(2'd1, d); check("R9 reset event", d, 32'h2);
    bus_read(2'd0, d); check("R9 reset mode", d, 32'h0);
    check("R8 reset irq", {31'd0, irq}, 32'd0);
    check("R3 reset sck", {31'd0, spi_sck}, 32'd0);

    // R1 lengths, loopback, MSB first
    bus_write(2'd2, 32'd1);
    set_mode(mk(1,0,0,1,1,0,0,7,0));  send(32'hA5, 32'hA5);        // R1 8 bits
    set_mode(mk(1,0,0,1,1,0,0,3,0));  send(32'h3C, 32'hC);         // R1 4 bits
    set_mode(mk(1,0,0,1,1,0,0,15,0)); send(32'h1234BEEF, 32'hBEEF); // R1 16 bits
    set_mode(mk(1,0,0,1,1,0,0,0,0));  send(32'hDEADBEEF, 32'hDEADBEEF); // R1 32 bits

    // R3 phase 1, idle high
    set_mode(mk(1,1,1,1,1,0,0,7,0));
    repeat (3) @(negedge clk);
    check("R3 idle high", {31'd0, spi_sck}, 32'd1);
    send(32'h5A, 32'h5A);
    set_mode(mk(1,1,0,0,1,0,1,11,0)); send(32'h0ABC, 32'hABC);     // R3 R4 phase 1 LSB 12 bits

    // R5 loopback vs miso
    miso_drv = 1'b1;
    set_mode(mk(1,0,0,1,0,0,0,7,0));  send(32'h00, 32'hFF);        // R5 miso sampled
    set_mode(mk(1,0,0,1,1,0,0,7,0));  send(32'h0F, 32'h0F);        // R5 miso ignored
    miso_drv = 1'b0;

    // R11 alternate offsets
    set_mode(mk(1,0,0,1,1,0,0,7,1));  send(32'hC3000000, 32'h00C30000);
    set_mode(mk(1,0,0,1,1,0,0,15,1)); send(32'hABCD0000, 32'hABCD0000);
    set_mode(mk(1,0,0,0,1,0,0,7,1));  send(32'h5A, 32'h5A00);
    set_mode(mk(1,0,0,1,1,0,0,0,1));  send(32'h12345678, 32'h12345678);

    // R2 / R4 / R9: scoreboard off
    bus_write(2'd2, 32'd0);
    set_mode(mk(1,0,0,1,1,0,2,7,0));
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h80;
    @(posedge clk); #1 bus_wr = 1'b0; bus_addr = 2'd1;
    @(negedge clk); check("R9 NF low after write", {31'd0, bus_rdata[1]}, 32'd0);
    @(negedge clk); check("R9 NF back high", {31'd0, bus_rdata[1]}, 32'd1);
    while (spi_sck !== 1'b1) @(negedge clk);
    check("R4 MSB first bit", {31'd0, spi_mosi}, 32'd1);
    cnt = 0;
    while (spi_sck !== 1'b0) begin @(negedge clk); cnt++; end
    while (spi_sck !== 1'b1) begin @(negedge clk); cnt++; end
    check("R2 period pm=2", cnt, 12);
    wait_ne(); bus_write(2'd1, 32'd1);

    set_mode(mk(1,0,0,0,1,1,0,7,0));
    bus_write(2'd3, 32'h80);
    while (spi_sck !== 1'b1) @(negedge clk);
    check("R4 LSB first bit", {31'd0, spi_mosi}, 32'd0);
    cnt = 0;
    while (spi_sck !== 1'b0) begin @(negedge clk); cnt++; end
    while (spi_sck !== 1'b1) begin @(negedge clk); cnt++; end
    check("R2 period div16", cnt, 64);
    wait_ne();
    check("R8 masked irq low", {31'd0, irq}, 32'd0);
    bus_read(2'd3, d); check("R7 data", d, 32'h80);
    bus_read(2'd3, d);
    bus_read(2'd1, d); check("R7 NE kept after read", {31'd0, d[0]}, 32'd1);
    bus_write(2'd2, 32'd1);
    @(negedge clk); check("R8 irq on mask", {31'd0, irq}, 32'd1);
    bus_write(2'd1, 32'd1);
    bus_read(2'd1, d); check("R7 NE cleared", {31'd0, d[0]}, 32'd0);
    check("R8 irq dropped", {31'd0, irq}, 32'd0);

    // R10 overrun
    set_mode(mk(1,0,0,1,1,0,0,7,0));
    exp_q.push_back(32'h11);
    cnt = sb_done + 1;
    @(negedge clk); bus_wr = 1'b1; bus_addr = 2'd3; bus_wdata = 32'h11;
    @(negedge clk); bus_wdata = 32'h22;
    @(posedge clk); #1 bus_wr = 1'b0;
    wait (sb_done == cnt);
    bus_read(2'd1, d); check("R10 overrun flag", {31'd0, d[2]}, 32'd1);
    bus_write(2'd2, 32'd4);
    @(negedge clk); check("R8 irq on overrun", {31'd0, irq}, 32'd1);
    bus_write(2'd1, 32'd4);
    bus_read(2'd1, d); check("R10 overrun cleared", {31'd0, d[2]}, 32'd0);
    bus_write(2'd2, 32'd0);

    // R6 disabled
    bus_read(2'd3, prev);
    bus_write(2'd0, mk(0,0,1,1,1,0,0,7,0));
    bus_write(2'd3, 32'hFF);
    bad = 0;
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (spi_sck !== 1'b1) bad++;
    end
    check("R6 sck held idle", bad, 0);
    bus_read(2'd1, d); check("R6 no flags", d, 32'h2);
    bus_read(2'd3, d); check("R6 data unchanged", d, prev);

    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end
endmodule